// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers nine level-sensitive interrupt sources and steers them onto three interrupt request outputs. Every source passes through a two-stage synchroniser and then a polarity stage that decides whether a high or a low level counts as active. Three of the sources have a hard-wired polarity. The other six take theirs from a configuration register.

Each output line owns one 32-bit register. The lower half of that register holds a per-source enable mask. The upper half shows, and clears, the per-source pending state for that line. A source latches pending on a line only while that line enables it. A line raises its request while any source is both enabled and pending on it.

Software acknowledges a source by writing a one into that source's pending position. If the level is still present, the source re-latches one cycle later. The register port is a plain byte-addressed word interface: address, write strobe, write data, and a combinational read-data return.

Top module: `irq_router`

## Requirements
- R1: After reset, every line register reads 0, the configuration word at offset 0x0 reads 0x00000102 (only the fixed polarity bits set), and all three request outputs are low.
- R2: Offset 0x0 holds one polarity bit per source in bits 0..8: 1 makes a high input level active, 0 makes a low level active. Configurable bits read back as written.
- R3: Sources 1 and 8 are always active-high and source 2 is always active-low. Writes to bits 1, 2 and 8 of offset 0x0 are ignored, and reads return 1, 0 and 1 there.
- R4: The register for line n (n = 0..2) sits at byte offset 0x4 + 4n. Its bits 0..8 are per-source enables that read back as written.
- R5: Bits 16..24 of a line register show source k's pending state at bit 16+k. A source that becomes active while enabled reads pending at the third rising edge after the input changes (two synchroniser stages, then the pending flop). Pending holds after the input goes inactive.
- R6: A source never becomes pending on a line whose enable bit for it is 0.
- R7: Writing 1 to bit 16+k of a line register clears source k's pending state on that line. Writing 0 there changes nothing.
- R8: A clear wins over a set in the same cycle. A source that is still active and enabled reads not pending right after the clearing edge and pending again one edge later.
- R9: Output n is a registered signal. It goes high one edge after some source is both enabled and pending on line n, and goes low one edge after no such source remains.
- R10: Writing 0x01FF0000 to a line register clears all of its pending bits and disables every source on it. Afterwards the line stays at 0 and its output stays low.
- R11: Reads of any other offset (including offsets that are not word-aligned) return 0. Writes there change no register. Write data in bits 9..15 and 25..31 of a line register, and in bits 9..31 of the configuration word, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, one write per cycle it is high |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_src_i | input | 9 | Raw interrupt source levels, asynchronous |
| irq_o | output | 3 | Interrupt request outputs, active high |

## Verification
A wrong enable or polarity bit in this block shows up within three edges as a pending bit that either appears when it should not or stays at 0. One edge after that, it shows as a request output with the wrong level. A clear that misses, or one that hits the wrong bit, is visible on the very next read of the line register. For a held level, it also shows as the one-cycle gap in pending that a correct design must produce. The random phase holds each input pattern steady and compares the full line words and all three outputs against values computed from the enable masks and the effective polarity. The directed cases count edges exactly around synchronisation, re-latching and the initialisation write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NSRC     = 9;
  localparam int unsigned NLINE    = 3;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 8;
  localparam int unsigned PEND_LSB = 16;
  localparam int unsigned SYNC_LEN = 2;
  // sources with hard-wired polarity and their values
  localparam logic [NSRC-1:0] FIX_MASK = 9'h106;
  localparam logic [NSRC-1:0] FIX_VAL  = 9'h102;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[0] <= '0;
        else         stage_q[0] <= raw_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  // active when synchronised level matches polarity
  assign act_o = ~(stage_q[STAGES-1] ^ pol_i);
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] act_i,
  input  logic         wr_i,
  input  logic [W-1:0] en_wr_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, pend_q, clr_eff;
  logic         irq_q;

  assign clr_eff = wr_i ? clr_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i) en_q <= en_wr_i;
      // clear beats set; level re-latches next cycle
      pend_q <= (pend_q | (act_i & en_q)) & ~clr_eff;
      irq_q  <= |(en_q & pend_q);
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R6
  no_set_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(en_q)) == '0);

  // R7
  clear_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & $past(clr_eff)) == '0);

  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(|(en_q & pend_q)));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_route_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [NSRC-1:0]  irq_src_i,
  output logic [NLINE-1:0] irq_o
);
  localparam int unsigned IDX_W = AW - 2;
  localparam logic [DW-1:0] INIT_WORD = DW'({NSRC{1'b1}}) << PEND_LSB;

  logic                        aligned, cfg_sel;
  logic [IDX_W-1:0]            idx;
  logic [NLINE-1:0]            line_sel;
  logic [NSRC-1:0]             pol_q, pol_eff, act;
  logic [NLINE-1:0][NSRC-1:0]  en_all, pend_all;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[AW-1:2];
  assign cfg_sel = aligned && (idx == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                pol_q <= '0;
    else if (wr_en_i && cfg_sel) pol_q <= wr_data_i[NSRC-1:0] & ~FIX_MASK;

  assign pol_eff = (pol_q & ~FIX_MASK) | FIX_VAL;

  irq_sync #(.W(NSRC), .STAGES(SYNC_LEN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (irq_src_i),
    .pol_i  (pol_eff),
    .act_o  (act)
  );

  for (genvar n = 0; n < NLINE; n++) begin : g_line
    assign line_sel[n] = aligned && (idx == IDX_W'(n + 1));

    irq_line #(.W(NSRC)) u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act),
      .wr_i    (wr_en_i && line_sel[n]),
      .en_wr_i (wr_data_i[NSRC-1:0]),
      .clr_i   (wr_data_i[PEND_LSB +: NSRC]),
      .en_o    (en_all[n]),
      .pend_o  (pend_all[n]),
      .irq_o   (irq_o[n])
    );

    // R10
    init_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && line_sel[n] && wr_data_i == INIT_WORD)
        |=> (en_all[n] == '0 && pend_all[n] == '0));
  end

  always_comb begin
    rd_data_o = '0;
    if (cfg_sel) rd_data_o[NSRC-1:0] = pol_eff;
    for (int n = 0; n < NLINE; n++) begin
      if (line_sel[n]) begin
        rd_data_o[NSRC-1:0]           = en_all[n];
        rd_data_o[PEND_LSB +: NSRC]   = pend_all[n];
      end
    end
  end

  // R11
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !cfg_sel && line_sel == '0) |=> ($stable(pol_q) && $stable(en_all)));

  // R11
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_sel && line_sel == '0) |-> rd_data_o == '0);
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [8:0]  src = '0;
  logic [2:0]  irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  localparam logic [8:0] FIXM = 9'h106;
  localparam logic [8:0] FIXV = 9'h102;

  always #2.5 clk = ~clk;

  irq_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_src_i(src), .irq_o(irq)
  );

  function automatic logic [8:0] pol_eff_f(input logic [8:0] p);
    return (p & ~FIXM) | FIXV;
  endfunction

  function automatic logic [8:0] act_f(input logic [8:0] s, input logic [8:0] pe);
    return ~(s ^ pe);
  endfunction

  task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [8:0]  pe, a_v, c;
    logic [8:0]  en [3];
    logic [8:0]  pd [3];
    logic [2:0]  exp_irq;
    void'($urandom(32'd4242));

    cyc(3);
    rst_n = 1'b1;
    src = 9'h0FD; // all inactive with configurable bits active-low
    cyc(1);
    // R1 reset state
    rd(8'h00, d); chk("R1 cfg", d, 32'h102);
    for (int n = 0; n < 3; n++) begin
      rd(8'(4 + 4*n), d); chk("R1 line", d, 32'h0);
    end
    chk("R1 irq", {29'h0, irq}, 32'h0);

    // R2 / R3 polarity
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R3 fixed bits set-all", d, 32'h1FB);
    wr(8'h00, 32'h0000_0000); rd(8'h00, d); chk("R3 fixed bits clear-all", d, 32'h102);
    wr(8'h00, 32'h0000_00A9); rd(8'h00, d); chk("R2 readback", d, 32'h1AB);
    wr(8'h00, 32'h0);

    // R11 unused bits and unmapped offsets
    cyc(4);
    wr(8'h04, 32'hFE00_FFFF); rd(8'h04, d); chk("R11 unused bits, R4 enables", d, 32'h1FF);
    wr(8'h04, 32'h01FF_0000); rd(8'h04, d); chk("R4 disable", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R11 cfg untouched", d, 32'h102);
    for (int n = 0; n < 3; n++) begin
      rd(8'(4 + 4*n), d); chk("R11 line untouched", d, 32'h0);
    end
    rd(8'h10, d); chk("R11 read unmapped", d, 32'h0);
    rd(8'h05, d); chk("R11 read unaligned", d, 32'h0);

    // R5 latency: source 0 active-high, on line 0
    wr(8'h00, 32'h1);
    src = 9'h0FC; cyc(4); // src0 low -> inactive
    wr(8'h04, 32'h0001_0001);
    cyc(2);
    rd(8'h04, d); chk("R5 idle", d, 32'h1);
    @(negedge clk); src = 9'h0FD;
    cyc(2); rd(8'h04, d); chk("R5 not yet after 2 edges", d, 32'h1);
    cyc(1); rd(8'h04, d); chk("R5 pending after 3 edges", d, 32'h0001_0001);
    chk("R9 irq lags pending", {29'h0, irq}, 32'h0);
    cyc(1); chk("R9 irq rises", {29'h0, irq}, 32'h1);
    rd(8'h08, d); chk("R6 disabled line stays clear", d, 32'h0);

    // R8 clear while level held
    wr(8'h04, 32'h0001_0001);
    rd(8'h04, d); chk("R8 cleared at edge", d, 32'h1);
    chk("R9 irq still high", {29'h0, irq}, 32'h1);
    cyc(1); rd(8'h04, d); chk("R8 re-latched", d, 32'h0001_0001);
    chk("R9 irq gap", {29'h0, irq}, 32'h0);
    cyc(1); chk("R9 irq back", {29'h0, irq}, 32'h1);

    // R7 write-zero no effect, write-one clears, pending holds
    src = 9'h0FC; cyc(4);
    rd(8'h04, d); chk("R5 pending holds", d, 32'h0001_0001);
    wr(8'h04, 32'h0000_0001); rd(8'h04, d); chk("R7 zero no effect", d, 32'h0001_0001);
    wr(8'h04, 32'h0001_0001); rd(8'h04, d); chk("R7 one clears", d, 32'h1);
    cyc(2); chk("R9 irq falls", {29'h0, irq}, 32'h0);

    // R10 init sequence
    src = 9'h0FD;
    wr(8'h0C, 32'h0000_01FF);
    cyc(4);
    wr(8'h04, 32'h01FF_0000);
    wr(8'h08, 32'h01FF_0000);
    wr(8'h0C, 32'h01FF_0000);
    for (int n = 0; n < 3; n++) begin
      rd(8'(4 + 4*n), d); chk("R10 cleared", d, 32'h0);
    end
    cyc(3);
    for (int n = 0; n < 3; n++) begin
      rd(8'(4 + 4*n), d); chk("R10 stays clear", d, 32'h0);
    end
    chk("R10 irq low", {29'h0, irq}, 32'h0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      logic [31:0] p;
      int ln;
      p  = $urandom;
      wr(8'h00, p);
      pe = pol_eff_f(p[8:0]);
      rd(8'h00, d); chk("R2 random readback", d, {23'h0, pe});
      src = 9'($urandom);
      a_v = act_f(src, pe);
      cyc(4);
      for (int n = 0; n < 3; n++) begin
        en[n] = 9'($urandom);
        wr(8'(4 + 4*n), {7'h0, 9'h1FF, 7'h0, en[n]});
      end
      cyc(3);
      for (int n = 0; n < 3; n++) begin
        pd[n] = en[n] & a_v;
        exp_irq[n] = |pd[n];
        rd(8'(4 + 4*n), d); chk("R5 R6 random pending", d, {7'h0, pd[n], 7'h0, en[n]});
      end
      chk("R9 random irq", {29'h0, irq}, {29'h0, exp_irq});
      src = ~pe; // all inactive
      cyc(4);
      for (int n = 0; n < 3; n++) begin
        rd(8'(4 + 4*n), d); chk("R5 random hold", d, {7'h0, pd[n], 7'h0, en[n]});
      end
      ln = int'($urandom % 3);
      c  = 9'($urandom);
      wr(8'(4 + 4*ln), {7'h0, c, 7'h0, en[ln]});
      pd[ln] = pd[ln] & ~c;
      rd(8'(4 + 4*ln), d); chk("R7 random clear", d, {7'h0, pd[ln], 7'h0, en[ln]});
      cyc(2);
      for (int n = 0; n < 3; n++) exp_irq[n] = |(en[n] & pd[n]);
      chk("R9 random irq after clear", {29'h0, irq}, {29'h0, exp_irq});
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule